// File: doc/BRIEF.md
# Bad-Block Marker Swap Unit

This unit moves a single byte between the data area of a page buffer and the first spare byte of the same page. In the data area the byte need not sit on a byte boundary. It starts at a chosen bit inside one data byte and runs on into the next data byte. The unit reads the two data bytes that hold the field and the spare byte. It then writes back three bytes: the field goes to the spare byte, and the old spare byte goes into the field. The bits around the field stay as they were.

The exchange is its own inverse. One copy of the unit can therefore run after a page is read and again before a page is written back. Running it twice restores the buffer. The unit reaches the buffer memory through a single byte-wide port with a one-cycle read latency. Another block computes the byte offset, the bit offset and the spare-area base. The unit captures them when it is started.

Top module: `marker_swap`

## Requirements
- R1: After an operation, the spare byte at `spareBase` holds bits `b` to `b+7` of the 16-bit value {data[off+1], data[off]}, where `b` is `bitOff` and bit 0 is data[off] bit 0.
- R2: After an operation, data[off] keeps bits [b-1:0] and holds the old spare byte's bits [7-b:0] in bits [7:b].
- R3: After an operation with b > 0, data[off+1] keeps bits [7:b] and holds the old spare byte's bits [7:8-b] in bits [b-1:0].
- R4: With b = 0 the full byte is exchanged: data[off] and the spare byte trade values, and data[off+1] is written back unchanged.
- R5: Two operations in a row with the same inputs restore all three bytes to their original values.
- R6: A start seen while idle gives a fixed 8-cycle sequence. Cycles 1 to 3 read off, off+1 and spareBase in that order. Cycle 4 is idle on the port. Cycles 5 to 7 write spareBase, off and off+1 in that order. `done` is high for exactly cycle 8 only. `busy` is high in cycles 1 to 8.
- R7: A start while busy is ignored. `memWe` is only high during cycles 5 to 7 of an operation. No address other than off, off+1 and spareBase is written.
- R8: `byteOff`, `bitOff` and `spareBase` are sampled only at the accepted start. Changes to them while busy have no effect.
- R9: After reset, `busy`, `done` and `memWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an exchange (accepted only while idle) |
| byteOff | input | ADDR_W | Address of the lower data byte holding the field |
| bitOff | input | 3 | Bit position of the field inside the lower data byte |
| spareBase | input | ADDR_W | Address of spare byte 0 |
| memAddr | output | ADDR_W | Buffer memory address |
| memWe | output | 1 | Buffer memory write enable |
| memWdata | output | 8 | Buffer memory write data |
| memRdata | input | 8 | Buffer memory read data, valid one cycle after the address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Bit offsets 0, 3, 7 and 5 are tried against data and spare bytes with mixed bit patterns. Offset 0 isolates the aligned whole-byte case, where the upper data byte must come back untouched. Offset 7 puts all but one bit of the field in the upper byte, which exposes a mask or shift direction that is off by one. Offset 3 catches a swapped merge of the two bytes. A second run at offset 5 checks that the exchange is its own inverse. A run in which the offsets are changed and start is pulsed mid-operation separates sampling at start from sampling while running. The neighbouring bytes are read back after every run to show that no stray write occurred.

// File: rtl/mswap_pkg.sv
package mswap_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int PAIR_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    SEL_LO    = 2'd0,
    SEL_HI    = 2'd1,
    SEL_SPARE = 2'd2
  } addrSel_e;

  typedef struct packed {
    logic     load;
    logic     capLo;
    logic     capHi;
    logic     capSpare;
    logic     we;
    addrSel_e sel;
  } swapCtl_t;
endpackage

// File: rtl/mswap_ctrl.sv
module mswap_ctrl
  import mswap_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output swapCtl_t ctl,
  output logic     busy,
  output logic     done
);
  typedef enum logic [3:0] {
    ST_IDLE, ST_RDLO, ST_RDHI, ST_RDSP, ST_CAP,
    ST_WRSP, ST_WRLO, ST_WRHI, ST_FIN
  } state_e;

  state_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) nextState = ST_RDLO;
      ST_RDLO: nextState = ST_RDHI;
      ST_RDHI: nextState = ST_RDSP;
      ST_RDSP: nextState = ST_CAP;
      ST_CAP:  nextState = ST_WRSP;
      ST_WRSP: nextState = ST_WRLO;
      ST_WRLO: nextState = ST_WRHI;
      ST_WRHI: nextState = ST_FIN;
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl = '0;
    ctl.sel = SEL_LO;
    unique case (state)
      ST_IDLE: ctl.load = start;
      ST_RDLO: ctl.sel = SEL_LO;
      ST_RDHI: begin ctl.sel = SEL_HI;    ctl.capLo = 1'b1; end
      ST_RDSP: begin ctl.sel = SEL_SPARE; ctl.capHi = 1'b1; end
      ST_CAP:  ctl.capSpare = 1'b1;
      ST_WRSP: begin ctl.sel = SEL_SPARE; ctl.we = 1'b1; end
      ST_WRLO: begin ctl.sel = SEL_LO;    ctl.we = 1'b1; end
      ST_WRHI: begin ctl.sel = SEL_HI;    ctl.we = 1'b1; end
      default: ;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_start_accept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  assert_we_in_op_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.we |-> busy);
endmodule

// File: rtl/mswap_dp.sv
module mswap_dp
  import mswap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  swapCtl_t          ctl,
  input  logic [ADDR_W-1:0] byteOff,
  input  logic [BIT_W-1:0]  bitOff,
  input  logic [ADDR_W-1:0] spareBase,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BYTE_W-1:0] memWdata
);
  logic [ADDR_W-1:0] offLo, spBase;
  logic [BIT_W-1:0]  bitSh;
  logic [BYTE_W-1:0] dLo, dHi, spOld;
  logic [PAIR_W-1:0] pair, shifted, fieldMask, merged;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offLo <= '0; spBase <= '0; bitSh <= '0;
      dLo <= '0; dHi <= '0; spOld <= '0;
    end else begin
      if (ctl.load) begin
        offLo  <= byteOff;
        bitSh  <= bitOff;
        spBase <= spareBase;
      end
      if (ctl.capLo)    dLo   <= memRdata;
      if (ctl.capHi)    dHi   <= memRdata;
      if (ctl.capSpare) spOld <= memRdata;
    end
  end

  assign pair      = {dHi, dLo};
  assign shifted   = pair >> bitSh;
  assign fieldMask = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}} << bitSh;
  assign merged    = (pair & ~fieldMask) | ({{BYTE_W{1'b0}}, spOld} << bitSh);

  always_comb begin
    unique case (ctl.sel)
      SEL_HI:    memAddr = offLo + ADDR_W'(1);
      SEL_SPARE: memAddr = spBase;
      default:   memAddr = offLo;
    endcase
  end

  always_comb begin
    unique case (ctl.sel)
      SEL_SPARE: memWdata = shifted[BYTE_W-1:0];
      SEL_HI:    memWdata = merged[PAIR_W-1:BYTE_W];
      default:   memWdata = merged[BYTE_W-1:0];
    endcase
  end

  assert_keep_hi_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.we && ctl.sel == SEL_HI && bitSh == '0) |-> memWdata == dHi);
  assert_hold_offsets_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load) |=> ($stable(offLo) && $stable(bitSh) && $stable(spBase)));
endmodule

// File: rtl/marker_swap.sv
module marker_swap
  import mswap_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] byteOff,
  input  logic [2:0]        bitOff,
  input  logic [ADDR_W-1:0] spareBase,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWdata,
  input  logic [7:0]        memRdata,
  output logic              busy,
  output logic              done
);
  swapCtl_t ctl;

  mswap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  mswap_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .byteOff(byteOff), .bitOff(bitOff), .spareBase(spareBase),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign memWe = ctl.we;

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rstN |=> (!busy && !done && !memWe));
endmodule

// File: tb/sim_marker_swap.sv
`timescale 1ns/1ps
module sim_marker_swap;
  localparam int AW = 10;
  localparam int MSZ = 1 << AW;

  logic clk = 0, rstN = 0, start = 0;
  logic [AW-1:0] byteOff = '0, spareBase = '0, memAddr;
  logic [2:0] bitOff = '0;
  logic memWe, busy, done;
  logic [7:0] memWdata, memRdata;
  logic [7:0] mem [0:MSZ-1];

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  marker_swap #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .byteOff(byteOff), .bitOff(bitOff),
    .spareBase(spareBase), .memAddr(memAddr), .memWe(memWe), .memWdata(memWdata),
    .memRdata(memRdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural model of one exchange: bit by bit field move
  task automatic model(input int d0, input int d1, input int sp, input int b,
                       output int src, output int n0, output int n1);
    int pv, np;
    pv = d0 | (d1 << 8);
    np = pv;
    src = 0;
    for (int i = 0; i < 8; i++) begin
      src = src | (((pv >> (b + i)) & 1) << i);
      np = (np & ~(1 << (b + i))) | (((sp >> i) & 1) << (b + i));
    end
    n0 = np & 255;
    n1 = (np >> 8) & 255;
  endtask

  task automatic runSwap(input int off, input int b, input int sp, input bit disturb,
                         input string tagSeq);
    int d0, d1, s0, src, n0, n1, lo1, hi2, sp1, a1;
    @(negedge clk);
    a1 = (off + 1) % MSZ;
    d0 = mem[off]; d1 = mem[a1]; s0 = mem[sp];
    lo1 = mem[(off + MSZ - 1) % MSZ]; hi2 = mem[(off + 2) % MSZ]; sp1 = mem[(sp + 1) % MSZ];
    model(d0, d1, s0, b, src, n0, n1);
    byteOff = AW'(off); bitOff = 3'(b); spareBase = AW'(sp); start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 1; k <= 8; k++) begin
      int expWe, expAddr, expData;
      expWe = (k >= 5 && k <= 7) ? 1 : 0;
      expAddr = (k == 1 || k == 6) ? off : (k == 2 || k == 7) ? a1 : sp;
      expData = (k == 5) ? src : (k == 6) ? n0 : n1;
      check({tagSeq, " busy"}, int'(busy), 1);
      check({tagSeq, " done"}, int'(done), (k == 8) ? 1 : 0);
      check({"R7 ", tagSeq, " we"}, int'(memWe), expWe);
      if (k <= 3 || expWe == 1) check({tagSeq, " addr"}, int'(memAddr), expAddr);
      if (expWe == 1) check({tagSeq, " wdata"}, int'(memWdata), expData);
      if (disturb && k == 2) begin
        byteOff = AW'(off + 5); bitOff = 3'(~b); spareBase = AW'(sp + 3); start = 1;
      end
      if (disturb && k == 4) start = 0;
      @(negedge clk);
    end
    check({"R7 ", tagSeq, " idle after"}, int'(busy), 0);
    check("R1 spare byte", int'(mem[sp]), src);
    check("R2 lower data byte", int'(mem[off]), n0);
    if (b == 0) check("R4 upper byte unchanged", int'(mem[a1]), d1);
    else        check("R3 upper data byte", int'(mem[a1]), n1);
    check("R7 neighbour below", int'(mem[(off + MSZ - 1) % MSZ]), lo1);
    check("R7 neighbour above", int'(mem[(off + 2) % MSZ]), hi2);
    check("R7 spare neighbour", int'(mem[(sp + 1) % MSZ]), sp1);
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int o0, o1, os;
    for (int i = 0; i < MSZ; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (3) @(negedge clk);
    check("R9 busy at reset", int'(busy), 0);
    check("R9 done at reset", int'(done), 0);
    check("R9 we at reset", int'(memWe), 0);
    rstN = 1;
    @(negedge clk);
    mem[100] = 8'hA5; mem[101] = 8'h3C; mem[600] = 8'hFF;
    runSwap(100, 0, 600, 0, "R4 seq b0");
    mem[200] = 8'hC6; mem[201] = 8'h59; mem[700] = 8'h0F;
    runSwap(200, 3, 700, 0, "R6 seq b3");
    mem[300] = 8'h80; mem[301] = 8'h7E; mem[800] = 8'h01;
    runSwap(300, 7, 800, 0, "R6 seq b7");
    mem[400] = 8'h2B; mem[401] = 8'hD4; mem[900] = 8'h96;
    o0 = mem[400]; o1 = mem[401]; os = mem[900];
    runSwap(400, 5, 900, 0, "R6 seq b5a");
    runSwap(400, 5, 900, 0, "R6 seq b5b");
    check("R5 restore lower", int'(mem[400]), o0);
    check("R5 restore upper", int'(mem[401]), o1);
    check("R5 restore spare", int'(mem[900]), os);
    runSwap(500, 2, 950, 1, "R8 seq disturbed");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule